// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Controller

This block sits on a simple 32-bit register bus and runs single-word operations against an array of one-time-programmable fuse words. The array is modelled here as on-chip flops. The array is split into banks of eight words. Software picks a word by writing a linear address (bank × 8 + word) into the control register. It then either requests a sense, which reads the word out into a read-data register, or writes a data value that is burned into the word. A burn only goes ahead when a 16-bit unlock key is present in the top half of the control register.

Each operation is a fixed three-phase sequence: a relax phase, then a strobe phase, then a second relax phase. All lengths are counted in clock cycles and come from a timing register that software loads. The controller shows a busy flag while a sequence runs. It raises a sticky error flag, and starts nothing, when a request is malformed: a burn without the key, a request while busy, or an address past the last bank. After every burn the key is wiped, so each burn needs a fresh unlock.

Register offsets on `bus_addr` (word index): 0 control, 1 control-set alias, 2 control-clear alias, 3 timing, 4 sense request, 5 read data, 6 burn data. Control layout: bits 31:16 unlock key, bit 9 error, bit 8 busy, bits 6:0 address. Timing layout: bits 21:16 sense strobe, bits 15:12 relax, bits 11:0 burn strobe.

Top module: `fuse_word_ctrl`

## Requirements
- R1: After reset, control reads 0, read data reads 0, and timing reads the low 22 bits of `TIMING_RST`.
- R2: Writing 1 in bit 0 at offset 4 starts a sense. Busy (control bit 8) is high for exactly 2·(relax+1)+(sense strobe+1) cycles. After busy falls, offset 5 returns the stored word.
- R3: Writing data at offset 6 while control bits 31:16 hold 0x3e77 starts a burn of the addressed word. Busy is high for exactly 2·(relax+1)+(burn strobe+1) cycles.
- R4: A burn ORs its data into the stored word, so stored bits never go from 1 to 0.
- R5: A burn request while the key is not 0x3e77 sets the error flag (control bit 9), starts nothing and leaves the word unchanged.
- R6: A sense or burn request while busy sets the error flag, and the running operation completes unchanged.
- R7: A request while the address (bits 6:0) is at least BANKS·8 sets the error flag and starts nothing.
- R8: When a burn completes, the unlock field reads back as 0.
- R9: The error flag stays set until a 1 is written to bit 9 at offset 2. A write to offset 0 does not clear it.
- R10: A write at offset 1 ORs its bits 31:16 and 6:0 into the key and address. A write at offset 2 clears the bits that are 1.
- R11: Writes at offsets 0 and 1 while busy leave the key and address unchanged.
- R12: A write at offset 4 with bit 0 at 0 starts nothing.
- R13: The address bank·8+word selects the word, so bank 1 word 3 and address 11 are the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |

## Verification
The bench builds the controller with BANKS = 2, so there are 16 words. This keeps address 16 within a 7-bit field while making it out of range, so the bad-address rejection can be exercised. The reset timing value is 0x0002_1004 (relax 1, sense strobe 2, burn strobe 4). Sequences then last 7 and 9 cycles, short enough that the bench can count every busy cycle exactly. The bench also rewrites the timing register, both to all-zero lengths and to longer values, to confirm that the phase lengths follow the register.

// File: rtl/fuse_ctrl_pkg.sv
package fuse_ctrl_pkg;
   typedef enum logic [1:0] {PH_IDLE, PH_RELAX_A, PH_STROBE, PH_RELAX_B} phase_e;

   localparam logic [15:0] UNLOCK_KEY = 16'h3e77;
   localparam int          WORDS_PER_BANK = 8;

   localparam logic [2:0] OFS_CTRL     = 3'd0;
   localparam logic [2:0] OFS_CTRL_SET = 3'd1;
   localparam logic [2:0] OFS_CTRL_CLR = 3'd2;
   localparam logic [2:0] OFS_TIMING   = 3'd3;
   localparam logic [2:0] OFS_SENSE    = 3'd4;
   localparam logic [2:0] OFS_RDATA    = 3'd5;
   localparam logic [2:0] OFS_PDATA    = 3'd6;

   localparam int BIT_BUSY = 8;
   localparam int BIT_ERR  = 9;
endpackage

// File: rtl/fuse_phase_timer.sv
module fuse_phase_timer
   import fuse_ctrl_pkg::*;
#(
   parameter int RELAX_W  = 4,
   parameter int STROBE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [RELAX_W-1:0]  relax_len,
   input  logic [STROBE_W-1:0] strobe_len,
   output logic                busy,
   output logic                strobe_end,
   output logic                op_end
);
   phase_e              phase;
   logic [STROBE_W-1:0] cnt;
   logic [STROBE_W-1:0] relax_hold;
   logic [STROBE_W-1:0] strobe_hold;
   logic                cnt_zero;

   if (STROBE_W < RELAX_W) begin : g_bad_width
      $error("fuse_phase_timer: STROBE_W must be at least RELAX_W");
   end

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         cnt         <= '0;
         relax_hold  <= '0;
         strobe_hold <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase       <= PH_RELAX_A;
               cnt         <= STROBE_W'(relax_len);
               relax_hold  <= STROBE_W'(relax_len);
               strobe_hold <= strobe_len;
            end
            PH_RELAX_A: if (cnt_zero) begin
               phase <= PH_STROBE;
               cnt   <= strobe_hold;
            end else cnt <= cnt - 1'b1;
            PH_STROBE: if (cnt_zero) begin
               phase <= PH_RELAX_B;
               cnt   <= relax_hold;
            end else cnt <= cnt - 1'b1;
            PH_RELAX_B: if (cnt_zero) phase <= PH_IDLE;
                        else          cnt   <= cnt - 1'b1;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy       = (phase != PH_IDLE);
   assign strobe_end = (phase == PH_STROBE)  && cnt_zero;
   assign op_end     = (phase == PH_RELAX_B) && cnt_zero;
endmodule

// File: rtl/fuse_store.sv
module fuse_store #(
   parameter int WORDS  = 32,
   parameter int DATA_W = 32,
   localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic              burn_en,
   input  logic [DATA_W-1:0] burn_data,
   output logic [DATA_W-1:0] cur_word
);
   logic [DATA_W-1:0] cells [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells[g] <= '0;
         else if (burn_en && (op_addr == ADDR_W'(g)))
            cells[g] <= cells[g] | burn_data;
      end
   end

   assign cur_word = cells[op_addr];
endmodule

// File: rtl/fuse_word_ctrl.sv
module fuse_word_ctrl
   import fuse_ctrl_pkg::*;
#(
   parameter int          BANKS      = 4,
   parameter logic [31:0] TIMING_RST = 32'h0002_1004
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [2:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata
);
   localparam int WORDS   = BANKS * WORDS_PER_BANK;
   localparam int ADDR_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int RELAX_W = 4;
   localparam int SRD_W   = 6;
   localparam int SPRG_W  = 12;

   if (BANKS < 1 || BANKS > 16) begin : g_bad_banks
      $error("fuse_word_ctrl: BANKS must lie in 1..16");
   end

   logic [15:0]        unlock_q;
   logic [6:0]         addr_q;
   logic               err_q;
   logic [SRD_W-1:0]   srd_q;
   logic [RELAX_W-1:0] relax_q;
   logic [SPRG_W-1:0]  sprg_q;
   logic [31:0]        rdata_q;
   logic [31:0]        pdata_q;
   logic [ADDR_W-1:0]  op_addr_q;
   logic               op_prog_q;

   logic wr, wr_ctrl, wr_set, wr_clr, wr_tim, clr_err;
   logic sense_req, prog_req, req, addr_ok, key_ok, reject, accept;
   logic busy, strobe_end, op_end;
   logic [SPRG_W-1:0] strobe_sel;
   logic [31:0] cur_word;

   assign wr        = bus_sel && bus_wr;
   assign wr_ctrl   = wr && (bus_addr == OFS_CTRL);
   assign wr_set    = wr && (bus_addr == OFS_CTRL_SET);
   assign wr_clr    = wr && (bus_addr == OFS_CTRL_CLR);
   assign wr_tim    = wr && (bus_addr == OFS_TIMING);
   assign clr_err   = wr_clr && bus_wdata[BIT_ERR];
   assign sense_req = wr && (bus_addr == OFS_SENSE) && bus_wdata[0];
   assign prog_req  = wr && (bus_addr == OFS_PDATA);
   assign req       = sense_req || prog_req;
   assign addr_ok   = int'(addr_q) < WORDS;
   assign key_ok    = (unlock_q == UNLOCK_KEY);
   assign reject    = req && (busy || !addr_ok || (prog_req && !key_ok));
   assign accept    = req && !reject;
   assign strobe_sel = prog_req ? sprg_q : SPRG_W'(srd_q);

   fuse_phase_timer #(.RELAX_W(RELAX_W), .STROBE_W(SPRG_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .relax_len  (relax_q),
      .strobe_len (strobe_sel),
      .busy       (busy),
      .strobe_end (strobe_end),
      .op_end     (op_end)
   );

   fuse_store #(.WORDS(WORDS), .DATA_W(32)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_addr   (op_addr_q),
      .burn_en   (strobe_end && op_prog_q),
      .burn_data (pdata_q),
      .cur_word  (cur_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlock_q <= '0;
         addr_q   <= '0;
      end else begin
         if (wr_ctrl && !busy) begin
            unlock_q <= bus_wdata[31:16];
            addr_q   <= bus_wdata[6:0];
         end else if (wr_set && !busy) begin
            unlock_q <= unlock_q | bus_wdata[31:16];
            addr_q   <= addr_q | bus_wdata[6:0];
         end else if (wr_clr) begin
            unlock_q <= unlock_q & ~bus_wdata[31:16];
            addr_q   <= addr_q & ~bus_wdata[6:0];
         end
         if (op_end && op_prog_q) unlock_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (reject)  err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srd_q   <= TIMING_RST[21:16];
         relax_q <= TIMING_RST[15:12];
         sprg_q  <= TIMING_RST[11:0];
      end else if (wr_tim) begin
         srd_q   <= bus_wdata[21:16];
         relax_q <= bus_wdata[15:12];
         sprg_q  <= bus_wdata[11:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_addr_q <= '0;
         op_prog_q <= 1'b0;
         pdata_q   <= '0;
         rdata_q   <= '0;
      end else begin
         if (accept) begin
            op_addr_q <= addr_q[ADDR_W-1:0];
            op_prog_q <= prog_req;
            pdata_q   <= bus_wdata;
         end
         if (strobe_end && !op_prog_q) rdata_q <= cur_word;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         case (bus_addr)
            OFS_CTRL, OFS_CTRL_SET, OFS_CTRL_CLR:
               bus_rdata = {unlock_q, 6'd0, err_q, busy, 1'b0, addr_q};
            OFS_TIMING: bus_rdata = {10'd0, srd_q, relax_q, sprg_q};
            OFS_RDATA:  bus_rdata = rdata_q;
            default:    bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/fuse_word_ctrl_chk.sv
module fuse_word_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        err_q,
   input logic [15:0] unlock_q,
   input logic [6:0]  addr_q,
   input logic        req,
   input logic        prog_req,
   input logic        addr_ok,
   input logic        key_ok,
   input logic        clr_err,
   input logic        wr_clr,
   input logic        strobe_end,
   input logic        op_end,
   input logic        op_prog_q,
   input logic [31:0] cur_word
);
   AST_BURN_OR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_end && op_prog_q |=> (cur_word & $past(cur_word)) == $past(cur_word)); // R4
   AST_BAD_KEY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req && !busy && addr_ok && !key_ok |=> err_q && !busy); // R5
   AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req && busy |=> err_q); // R6
   AST_BAD_ADDR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      req && !busy && !addr_ok |=> err_q && !busy); // R7
   AST_KEY_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
      op_end && op_prog_q |=> unlock_q == 16'd0); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q && !clr_err |=> err_q); // R9
   AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !wr_clr |=> $stable(addr_q)); // R11
endmodule

bind fuse_word_ctrl fuse_word_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .err_q      (err_q),
   .unlock_q   (unlock_q),
   .addr_q     (addr_q),
   .req        (req),
   .prog_req   (prog_req),
   .addr_ok    (addr_ok),
   .key_ok     (key_ok),
   .clr_err    (clr_err),
   .wr_clr     (wr_clr),
   .strobe_end (strobe_end),
   .op_end     (op_end),
   .op_prog_q  (op_prog_q),
   .cur_word   (cur_word)
);

// File: tb/fuse_word_ctrl_test.sv
module fuse_word_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   fuse_word_ctrl #(.BANKS(2), .TIMING_RST(32'h0002_1004)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   // each row: address, burn data, expected word after the burn
   localparam logic [6:0]  V_ADDR [6] = '{7'd0, 7'd0, 7'd11, 7'd15, 7'd11, 7'd8};
   localparam logic [31:0] V_DATA [6] = '{32'h0000_00F0, 32'h0F00_000F, 32'hAAAA_5555,
                                          32'h8000_0001, 32'h0000_FFFF, 32'h1234_5678};
   localparam logic [31:0] V_EXP  [6] = '{32'h0000_00F0, 32'h0F00_00FF, 32'hAAAA_5555,
                                          32'h8000_0001, 32'hAAAA_FFFF, 32'h1234_5678};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   // counts busy cycles following a start write; called right after wr_reg
   task automatic count_busy(output int n);
      logic [31:0] c;
      n = 0;
      rd_reg(3'd0, c);
      while (c[8] && n < 5000) begin
         n++;
         @(negedge clk);
         rd_reg(3'd0, c);
      end
   endtask

   task automatic sense(input logic [6:0] a, output logic [31:0] d);
      int n;
      wr_reg(3'd0, {16'h0, 9'h0, a});
      wr_reg(3'd4, 32'h1);
      count_busy(n);
      rd_reg(3'd5, d);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_reg(3'd0, r); check("R1 ctrl", r, 32'h0);
      rd_reg(3'd5, r); check("R1 rdata", r, 32'h0);
      rd_reg(3'd3, r); check("R1 timing", r, 32'h0002_1004);

      // table walk: R3 burn duration, R4 OR accumulation, R2 sense result
      for (int i = 0; i < 6; i++) begin
         wr_reg(3'd0, {16'h3e77, 9'h0, V_ADDR[i]});
         wr_reg(3'd6, V_DATA[i]);
         count_busy(n);
         check("R3 burn busy cycles", 32'(n), 32'd9);
         rd_reg(3'd0, r); check("R8 key wiped", {16'h0, r[31:16]}, 32'h0);
         wr_reg(3'd4, 32'h1);
         count_busy(n);
         check("R2 sense busy cycles", 32'(n), 32'd7);
         rd_reg(3'd5, r); check("R2 R4 sensed word", r, V_EXP[i]);
      end

      // R13 bank 1 word 3 is address 11
      sense(7'd11, r); check("R13 bank1 word3", r, 32'hAAAA_FFFF);

      // R5 wrong key: rejected, error set, word unchanged
      wr_reg(3'd0, {16'h3e76, 9'h0, 7'd3});
      wr_reg(3'd6, 32'hFFFF_FFFF);
      rd_reg(3'd0, r); check("R5 err no busy", {22'h0, r[9:8]}, 32'h2);
      // R9 a direct ctrl write does not clear error
      wr_reg(3'd0, {16'h0, 9'h0, 7'd3});
      rd_reg(3'd0, r); check("R9 err sticky", {31'h0, r[9]}, 32'h1);
      wr_reg(3'd2, 32'h0000_0200);
      rd_reg(3'd0, r); check("R9 err cleared", {31'h0, r[9]}, 32'h0);
      sense(7'd3, r); check("R5 word unchanged", r, 32'h0);

      // R7 out-of-range address
      wr_reg(3'd0, {16'h0, 9'h0, 7'd16});
      wr_reg(3'd4, 32'h1);
      rd_reg(3'd0, r); check("R7 err no busy", {22'h0, r[9:8]}, 32'h2);
      wr_reg(3'd2, 32'h0000_0200);

      // R12 sense request with bit 0 clear starts nothing
      wr_reg(3'd0, {16'h0, 9'h0, 7'd0});
      wr_reg(3'd4, 32'hFFFF_FFFE);
      rd_reg(3'd0, r); check("R12 no start", {22'h0, r[9:8]}, 32'h0);

      // R10 set / clear aliases
      wr_reg(3'd1, 32'h3e00_0005);
      wr_reg(3'd1, 32'h0077_0002);
      rd_reg(3'd0, r); check("R10 set alias", r, 32'h3e77_0007);
      wr_reg(3'd2, 32'h0070_0004);
      rd_reg(3'd0, r); check("R10 clear alias", r, 32'h3e07_0003);

      // R6 request while busy; R11 ctrl writes ignored while busy
      wr_reg(3'd0, {16'h0, 9'h0, 7'd11});
      wr_reg(3'd4, 32'h1);
      wr_reg(3'd4, 32'h1);
      wr_reg(3'd0, {16'h3e77, 9'h0, 7'd5});
      wr_reg(3'd1, 32'h0000_0040);
      count_busy(n);
      rd_reg(3'd0, r); check("R6 err after busy request", {31'h0, r[9]}, 32'h1);
      check("R11 ctrl held during busy", r & 32'hFFFF_007F, 32'h0000_000B);
      rd_reg(3'd5, r); check("R6 running sense intact", r, 32'hAAAA_FFFF);
      wr_reg(3'd2, 32'h0000_0200);

      // R2 R3 timing register drives phase lengths
      wr_reg(3'd3, 32'h0000_0000);
      wr_reg(3'd4, 32'h1);
      count_busy(n); check("R2 zero timing sense", 32'(n), 32'd3);
      wr_reg(3'd3, 32'h0005_300A);
      wr_reg(3'd0, {16'h3e77, 9'h0, 7'd2});
      wr_reg(3'd6, 32'h0000_0001);
      count_busy(n); check("R3 long burn", 32'(n), 32'd19);
      wr_reg(3'd4, 32'h1);
      count_busy(n); check("R2 long sense", 32'(n), 32'd14);
      rd_reg(3'd5, r); check("R3 burned word", r, 32'h0000_0001);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule